// File: doc/BRIEF.md
# Per-Core Software Interrupt Register File

This block lets any bus master send a software interrupt to one of a set of cores. Each core owns one 32-bit word in a small address window. Bit 0 of that word drives the core's software-interrupt output, and the higher bits are reserved. Core `i` sits at byte offset `4*i`, so the word index is the address shifted right by two. Only offsets below `4*NUM_CORES` decode.

A build-time mode parameter selects one of two behaviours:

- **Machine mode** (`SUPERVISOR = 0`): each bit is a pending level. Software can set it, clear it and read it back.
- **Supervisor mode** (`SUPERVISOR = 1`): the block only signals. Writing a 1 gives a single-cycle pulse on the core's output, and the receiving core latches and clears it on its own side. Writes of 0 do nothing, and reads return zero.

Requests arrive on a valid/ready channel and every accepted request returns exactly one response on a second valid/ready channel.

- A request transfers on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is low only while a response is waiting and `rsp_ready` is low. This is one slot of back-pressure.
- A waiting response holds its data stable until `rsp_ready` is seen high.
- A new request may transfer on the same edge that the waiting response is consumed.

Top module: `swi_regfile`

## Requirements
- R1: After reset every interrupt output is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: An accepted write with size code 2 (4 bytes; codes 0, 1 and 3 mean 1, 2 and 8 bytes), word-aligned offset `4*i` with `i < NUM_CORES`, and data bit 0 = 1 raises core `i`'s output on the clock edge that accepts it.
- R3: In machine mode a valid write with bit 0 = 0 lowers that core's output, and the output otherwise holds its level.
- R4: In machine mode a valid read returns 1 in bit 0 when that core's interrupt is pending and 0 when it is not.
- R5: In supervisor mode a valid write of 1 makes the core's output high for exactly the one cycle after the accepting edge.
- R6: In supervisor mode a write of 0 leaves the outputs low, and every read returns 0.
- R7: An access with a size code other than 2, an offset with bits [1:0] not 00, or a word index at or above `NUM_CORES` reads 0 and changes no output.
- R8: Data bits 31..1 are ignored on write, and they read as 0 in every response.
- R9: Each accepted request yields one response, and a write's response data is 0. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response data holds.
- R10: A write to one core's word changes no other core's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_size | input | 2 | log2 of access bytes; only 2 is legal |
| req_wdata | input | 32 | Write data, bit 0 used |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data (0 for writes and illegal accesses) |
| irq_o | output | NUM_CORES | Per-core software-interrupt outputs |

## Verification
The bench builds the block twice, each with an 8-bit address:

- a machine-mode copy with four cores, and
- a supervisor-mode copy with three cores.

The four-core copy puts the last word (offset 12) and the first illegal word (offset 16) on exact power-of-two boundaries. The three-core copy leaves index 3 decodable by the index bits but out of range, which exposes a range check that leans on index width alone. The machine copy also drives held back-pressure, so response stability and request stalling are exercised.

// File: rtl/swi_pkg.sv
package swi_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_DWORD = 2'd3
  } acc_size_e;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned WORD_SHIFT = 2;
endpackage

// File: rtl/swi_decode.sv
module swi_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  import swi_pkg::*;

  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_CORES);

  logic [ADDR_W-1:0] word;
  logic              aligned;
  logic              sized;

  assign word    = addr >> WORD_SHIFT;
  assign aligned = (addr[WORD_SHIFT-1:0] == '0);
  assign sized   = (size == ACC_WORD);
  assign hit     = aligned && sized && (word < LIMIT);
  assign idx     = word[IDX_W-1:0];
endmodule

// File: rtl/swi_slot.sv
module swi_slot #(
  parameter bit SUPERVISOR = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic irq,
  output logic rd_bit
);
  if (SUPERVISOR) begin : g_sup
    logic pulse_q;
    always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= wr_en && wr_bit;
    end
    assign irq    = pulse_q;
    assign rd_bit = 1'b0;
  end else begin : g_mach
    logic pend_q;
    always_ff @(posedge clk) begin
      if (!rst_n)     pend_q <= 1'b0;
      else if (wr_en) pend_q <= wr_bit;
    end
    assign irq    = pend_q;
    assign rd_bit = pend_q;
  end
endmodule

// File: rtl/swi_resp.sv
module swi_resp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] data_in,
  output logic              can_take,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  assign can_take = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= data_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/swi_regfile.sv
module swi_regfile #(
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned ADDR_W     = 8,
  parameter bit          SUPERVISOR = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [1:0]            req_size,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [31:0]           rsp_rdata,
  output logic [NUM_CORES-1:0]  irq_o
);
  import swi_pkg::*;

  localparam int unsigned IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic                 hit;
  logic [IDX_W-1:0]     idx;
  logic                 acc;
  logic [NUM_CORES-1:0] sel;
  logic [NUM_CORES-1:0] slot_rd;
  logic                 rd_bit;
  logic [DATA_W-1:0]    rd_word;
  logic                 unused_wdata_hi;

  assign unused_wdata_hi = ^req_wdata[31:1];
  assign acc = req_valid && req_ready;

  swi_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_CORES(NUM_CORES),
    .IDX_W    (IDX_W)
  ) u_decode (
    .addr(req_addr),
    .size(req_size),
    .hit (hit),
    .idx (idx)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    assign sel[i] = hit && (idx == IDX_W'(i));
    swi_slot #(.SUPERVISOR(SUPERVISOR)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (acc && req_write && sel[i]),
      .wr_bit(req_wdata[0]),
      .irq   (irq_o[i]),
      .rd_bit(slot_rd[i])
    );
  end

  assign rd_bit  = |(sel & slot_rd);
  assign rd_word = req_write ? '0 : {{(DATA_W-1){1'b0}}, rd_bit};

  swi_resp #(.DATA_W(DATA_W)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (acc),
    .data_in  (rd_word),
    .can_take (req_ready),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/swi_regfile_chk.sv
module swi_regfile_chk #(
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned ADDR_W     = 8,
  parameter bit          SUPERVISOR = 1'b0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [31:0]          rsp_rdata,
  input logic [NUM_CORES-1:0] irq_o
);
  // R9
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[31:1] == 31'd0));

  // R6
  sup_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SUPERVISOR && rsp_valid) |-> (rsp_rdata == 32'd0));

  // R5
  sup_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SUPERVISOR && (irq_o != '0)) |-> $past(req_valid && req_ready && req_write));

  // R3
  mach_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!SUPERVISOR && !(req_valid && req_ready)) |=> $stable(irq_o));

  // R10
  one_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(irq_o ^ $past(irq_o)) <= 1) || SUPERVISOR);

  logic unused_chk;
  assign unused_chk = ^req_addr;
endmodule

bind swi_regfile swi_regfile_chk #(
  .NUM_CORES (NUM_CORES),
  .ADDR_W    (ADDR_W),
  .SUPERVISOR(SUPERVISOR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata),
  .irq_o    (irq_o)
);

// File: tb/swi_regfile_test.sv
module swi_regfile_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // machine-mode instance, 4 cores
  logic        m_req_valid = 0, m_req_write = 0, m_rsp_ready = 1;
  logic [7:0]  m_req_addr = 0;
  logic [1:0]  m_req_size = 2;
  logic [31:0] m_req_wdata = 0;
  logic        m_req_ready, m_rsp_valid;
  logic [31:0] m_rsp_rdata;
  logic [3:0]  m_irq;

  swi_regfile #(.NUM_CORES(4), .ADDR_W(8), .SUPERVISOR(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(m_req_valid), .req_ready(m_req_ready),
    .req_write(m_req_write), .req_addr(m_req_addr), .req_size(m_req_size),
    .req_wdata(m_req_wdata), .rsp_valid(m_rsp_valid), .rsp_ready(m_rsp_ready),
    .rsp_rdata(m_rsp_rdata), .irq_o(m_irq));

  // supervisor-mode instance, 3 cores
  logic        s_req_valid = 0, s_req_write = 0, s_rsp_ready = 1;
  logic [7:0]  s_req_addr = 0;
  logic [1:0]  s_req_size = 2;
  logic [31:0] s_req_wdata = 0;
  logic        s_req_ready, s_rsp_valid;
  logic [31:0] s_rsp_rdata;
  logic [2:0]  s_irq;

  swi_regfile #(.NUM_CORES(3), .ADDR_W(8), .SUPERVISOR(1'b1)) uut_sup (
    .clk(clk), .rst_n(rst_n), .req_valid(s_req_valid), .req_ready(s_req_ready),
    .req_write(s_req_write), .req_addr(s_req_addr), .req_size(s_req_size),
    .req_wdata(s_req_wdata), .rsp_valid(s_rsp_valid), .rsp_ready(s_rsp_ready),
    .rsp_rdata(s_rsp_rdata), .irq_o(s_irq));

  typedef struct packed {
    logic        wr;
    logic [1:0]  size;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic [3:0]  exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 8'h00, 32'h0000_0001, 32'h0, 4'b0001, 4'd2},  // R2
    '{1'b0, 2'd2, 8'h00, 32'h0,         32'h1, 4'b0001, 4'd4},  // R4
    '{1'b1, 2'd2, 8'h08, 32'hFFFF_FFFF, 32'h0, 4'b0101, 4'd10}, // R10
    '{1'b0, 2'd2, 8'h08, 32'h0,         32'h1, 4'b0101, 4'd4},
    '{1'b0, 2'd2, 8'h04, 32'h0,         32'h0, 4'b0101, 4'd4},
    '{1'b1, 2'd2, 8'h00, 32'hFFFF_FFFE, 32'h0, 4'b0100, 4'd8},  // R8
    '{1'b0, 2'd2, 8'h00, 32'h0,         32'h0, 4'b0100, 4'd3},  // R3
    '{1'b1, 2'd2, 8'h10, 32'h0000_0001, 32'h0, 4'b0100, 4'd7},  // R7
    '{1'b1, 2'd2, 8'h06, 32'h0000_0001, 32'h0, 4'b0100, 4'd7},
    '{1'b0, 2'd2, 8'h0A, 32'h0,         32'h0, 4'b0100, 4'd7},
    '{1'b1, 2'd1, 8'h0C, 32'h0000_0001, 32'h0, 4'b0100, 4'd7},
    '{1'b0, 2'd0, 8'h08, 32'h0,         32'h0, 4'b0100, 4'd7},
    '{1'b1, 2'd2, 8'h0C, 32'h0000_0003, 32'h0, 4'b1100, 4'd2},
    '{1'b0, 2'd2, 8'h0C, 32'h0,         32'h1, 4'b1100, 4'd4},
    '{1'b0, 2'd2, 8'h10, 32'h0,         32'h0, 4'b1100, 4'd7},
    '{1'b1, 2'd2, 8'h08, 32'h0,         32'h0, 4'b1000, 4'd3}
  };

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic m_issue(input logic wr, input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    m_req_valid = 1; m_req_write = wr; m_req_size = sz; m_req_addr = a; m_req_wdata = d;
    @(negedge clk);
    m_req_valid = 0;
  endtask

  task automatic s_issue(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    s_req_valid = 1; s_req_write = wr; s_req_size = 2; s_req_addr = a; s_req_wdata = d;
    @(negedge clk);
    s_req_valid = 0;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(m_irq == 0 && s_irq == 0, "R1 irq in reset", {28'd0, m_irq}, 0);
    chk(!m_rsp_valid && m_req_ready, "R1 handshake in reset", {30'd0, m_rsp_valid, m_req_ready}, 1);
    rst_n = 1;
    @(negedge clk);
    chk(m_irq == 0 && !m_rsp_valid, "R1 after reset", {28'd0, m_irq}, 0);

    for (int v = 0; v < NV; v++) begin
      m_issue(VECS[v].wr, VECS[v].size, VECS[v].addr, VECS[v].wdata);
      chk(m_rsp_valid && m_rsp_rdata == VECS[v].exp_rd,
          $sformatf("R%0d vector %0d rdata", VECS[v].req, v), m_rsp_rdata, VECS[v].exp_rd);
      chk(m_irq == VECS[v].exp_irq,
          $sformatf("R%0d vector %0d irq", VECS[v].req, v), {28'd0, m_irq}, {28'd0, VECS[v].exp_irq});
    end

    // R9 back-pressure: read core 3 (pending) with consumer stalled
    @(negedge clk);
    m_rsp_ready = 0;
    m_req_valid = 1; m_req_write = 0; m_req_size = 2; m_req_addr = 8'h0C; m_req_wdata = 0;
    @(negedge clk);
    chk(m_rsp_valid && m_rsp_rdata == 1, "R9 stalled read data", m_rsp_rdata, 1);
    chk(!m_req_ready, "R9 ready low while stalled", {31'd0, m_req_ready}, 0);
    m_req_write = 1;
    @(negedge clk);
    chk(m_irq == 4'b1000, "R9 stalled write not taken", {28'd0, m_irq}, 8);
    chk(m_rsp_valid && m_rsp_rdata == 1, "R9 response held", m_rsp_rdata, 1);
    m_rsp_ready = 1;
    @(negedge clk);
    m_req_valid = 0;
    chk(m_irq == 4'b0000, "R3 write taken after release", {28'd0, m_irq}, 0);
    chk(m_rsp_valid && m_rsp_rdata == 0, "R9 write response zero", m_rsp_rdata, 0);
    @(negedge clk);
    chk(!m_rsp_valid, "R9 response consumed", {31'd0, m_rsp_valid}, 0);

    // R5 supervisor pulse on core 1
    s_issue(1, 8'h04, 32'h1);
    chk(s_irq == 3'b010, "R5 pulse high", {29'd0, s_irq}, 2);
    @(negedge clk);
    chk(s_irq == 3'b000, "R5 pulse one cycle", {29'd0, s_irq}, 0);
    // R6 write of 0 has no effect
    s_issue(1, 8'h04, 32'h0);
    chk(s_irq == 3'b000, "R6 write zero no pulse", {29'd0, s_irq}, 0);
    @(negedge clk);
    chk(s_irq == 3'b000, "R6 write zero stays low", {29'd0, s_irq}, 0);
    // R6 read returns 0
    s_issue(0, 8'h04, 32'h0);
    chk(s_rsp_valid && s_rsp_rdata == 0, "R6 read zero", s_rsp_rdata, 0);
    // R7 index 3 out of range for 3 cores
    s_issue(1, 8'h0C, 32'h1);
    chk(s_irq == 3'b000, "R7 out-of-range no pulse", {29'd0, s_irq}, 0);
    // R5 last core
    s_issue(1, 8'h08, 32'hFFFF_FFFF);
    chk(s_irq == 3'b100, "R5 last core pulse", {29'd0, s_irq}, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule